// File: doc/BRIEF.md
# Cycle-Bit Transfer Ring Fetcher

This block walks a ring of 16-byte transfer request blocks held in memory and hands the ones it owns to a downstream consumer. Ownership is not tracked with head and tail pointers. Each block carries a single cycle flag, and the fetcher owns a block only while that flag equals the fetcher's own consumer cycle state. When the flag does not match, the producer has not yet written that slot, so the fetcher treats the ring as empty. It then parks at that address until it is rung again.

Software first loads a start address and an initial cycle state while the fetcher is idle. A one-cycle doorbell pulse then starts fetching. The fetcher reads one whole 128-bit block per request through a simple request/response port. It steps through segments by following link blocks, which redirect the fetch pointer and can invert the consumer cycle state. It silently consumes no-op blocks. It forwards every other owned block on a valid/ready stream together with its chain and interrupt-on-completion flags. Two control pulses stop the walk: a pause stops it after the block in flight, and an abort stops it at once. The dequeue pointer and the cycle state are visible at all times.

Top module: `trb_ring_consumer`

## Requirements
- R1: After reset the fetcher is idle: `running`, `mem_req_valid` and `out_valid` are low, `deq_ptr` is zero and `ccs` is zero.
- R2: A `load` pulse while idle sets `deq_ptr` to `load_ptr` with its low 4 bits cleared, and sets `ccs` to `load_ccs`. A `load` pulse while running changes neither.
- R3: A `doorbell` pulse while idle starts fetching at `deq_ptr`. `running` rises only in the cycle after a doorbell, and stays high until the fetcher returns to idle.
- R4: A block is owned when bit 0 of its control word (bits 127:96) equals `ccs`. Owned blocks that are neither link nor no-op are forwarded in ring order:
  - `out_param` carries bits 63:0 and `out_status` carries bits 95:64.
  - `out_type` carries control bits 15:10.
  - `out_chain` carries control bit 4 and `out_ioc` carries control bit 5.
  - `deq_ptr` advances by 16 on the handshake.
- R5: When a fetched block is not owned, the fetcher goes idle without forwarding it and without moving `deq_ptr`. The next doorbell fetches the same address again.
- R6: An owned block of type 6 (link) is not forwarded. `deq_ptr` takes bits 63:0 of the block, truncated to the address width, with the low 6 bits cleared.
- R7: A link block with control bit 1 set inverts `ccs`. With that bit clear, `ccs` is kept.
- R8: An owned block of type 8 (no-op) is consumed: `deq_ptr` advances by 16 and nothing is forwarded.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the forwarded fields stay constant, unless an abort intervenes.
- R10: After a `pause_req` pulse, the block in flight completes and the fetcher then goes idle, with `deq_ptr` pointing past that block.
- R11: After an `abort_req` pulse, the fetcher goes idle at once. A block waiting on the output is withdrawn, and `deq_ptr` is not advanced past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| doorbell | input | 1 | Start pulse, acted on only when idle |
| load | input | 1 | Load pulse for start pointer and cycle state, acted on only when idle |
| load_ptr | input | ADDR_W | Start byte address |
| load_ccs | input | 1 | Initial consumer cycle state |
| pause_req | input | 1 | Stop after the current block |
| abort_req | input | 1 | Stop immediately |
| mem_req_valid | output | 1 | Read request for one block |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the requested block |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Whole block, word 0 in bits 31:0 |
| out_valid | output | 1 | Forwarded block valid |
| out_ready | input | 1 | Downstream accepts the block |
| out_param | output | 64 | Block words 0 and 1 |
| out_status | output | 32 | Block word 2 |
| out_type | output | 6 | Block type field |
| out_chain | output | 1 | Chain flag |
| out_ioc | output | 1 | Interrupt-on-completion flag |
| running | output | 1 | Fetcher is active |
| deq_ptr | output | ADDR_W | Current dequeue byte address |
| ccs | output | 1 | Current consumer cycle state |

## Verification
Several properties are checked on every cycle:
- The output holds steady under backpressure.
- `running` rises only after a doorbell.
- The fetcher stops in the cycle after it finds an unowned block.
- An aborted output is withdrawn.
- A link always leaves the pointer segment-aligned.
- Memory responses arrive only while a read is outstanding.

Other behaviour can only be shown by the bench's scenarios:
- The exact order and content of the forwarded blocks across a segment change.
- The skipping of no-op blocks.
- The inversion of the cycle state after a toggling link.
- The resume at the parked address once software hands the slot over.
- The pointer values left behind by pause, abort and loads that arrive while running.

// File: rtl/trb_ring_pkg.sv
// Package: shared constants and types of the transfer ring fetcher.
// Assumes a block is four little-endian 32-bit words packed into 128 bits,
// with word 0 in bits 31:0 and the control word in bits 127:96.
package trb_ring_pkg;

    localparam int TRB_W        = 128;
    localparam int TRB_BYTES    = 16;
    localparam int TYPE_W       = 6;
    localparam int CTRL_LSB     = 96;

    // control word bit positions
    localparam int CB_CYCLE     = 0;
    localparam int CB_TOGGLE    = 1;
    localparam int CB_CHAIN     = 4;
    localparam int CB_IOC       = 5;
    localparam int CB_TYPE_LSB  = 10;

    localparam logic [TYPE_W-1:0] TYPE_LINK = 6'd6;
    localparam logic [TYPE_W-1:0] TYPE_NOOP = 6'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_EVAL,
        ST_OUT
    } fetch_st_t;

    typedef struct packed {
        logic              owned;
        logic              is_link;
        logic              is_noop;
        logic              toggle;
        logic              chain;
        logic              ioc;
        logic [TYPE_W-1:0] ttype;
    } trb_info_t;

endpackage

// File: rtl/trb_ring_decode.sv
// Module: combinational decode of a block's control word.
// Decides ownership by comparing the cycle flag with the consumer cycle state
// and classifies link and no-op blocks. Assumes ctrl is the 4th word.
module trb_ring_decode
    import trb_ring_pkg::*;
(
    input  logic [31:0] ctrl,
    input  logic        ccs,
    output trb_info_t   info
);

    logic unused_ctrl_bits;

    // Purpose: extract fields and classify the block.
    always_comb begin
        info.ttype   = ctrl[CB_TYPE_LSB +: TYPE_W];
        info.owned   = (ctrl[CB_CYCLE] == ccs);
        info.is_link = (info.ttype == TYPE_LINK);
        info.is_noop = (info.ttype == TYPE_NOOP);
        info.toggle  = ctrl[CB_TOGGLE];
        info.chain   = ctrl[CB_CHAIN];
        info.ioc     = ctrl[CB_IOC];
    end

    assign unused_ctrl_bits = ^{ctrl[31:CB_TYPE_LSB+TYPE_W], ctrl[CB_TYPE_LSB-1:CB_IOC+1],
                                ctrl[CB_CHAIN-1:CB_TOGGLE+1]};

endmodule

// File: rtl/trb_ring_ptr.sv
// Module: dequeue pointer and consumer cycle state registers.
// Loads, advances by one block, or jumps to a segment-aligned link target.
// Assumes the controller raises at most one of load_en, adv, link_en per cycle.
module trb_ring_ptr #(
    parameter int ADDR_W         = 32,
    parameter int TRB_BYTES      = 16,
    parameter int SEG_ALIGN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_ptr,
    input  logic              load_ccs,
    input  logic              adv,
    input  logic              link_en,
    input  logic [ADDR_W-1:0] link_ptr,
    input  logic              link_tog,
    output logic [ADDR_W-1:0] ptr,
    output logic              ccs
);

    localparam int STEP_BITS = $clog2(TRB_BYTES);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(TRB_BYTES);
    localparam logic [ADDR_W-1:0] TRB_MASK = ~((ADDR_W'(1) << STEP_BITS) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] SEG_MASK = ~((ADDR_W'(1) << SEG_ALIGN_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] ptr_q;
    logic              ccs_q;

    // Purpose: update pointer and cycle state on load, advance or link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            ccs_q <= 1'b0;
        end else if (load_en) begin
            ptr_q <= load_ptr & TRB_MASK;
            ccs_q <= load_ccs;
        end else if (link_en) begin
            ptr_q <= link_ptr & SEG_MASK;
            ccs_q <= ccs_q ^ link_tog;
        end else if (adv) begin
            ptr_q <= ptr_q + STEP;
        end
    end

    assign ptr = ptr_q;
    assign ccs = ccs_q;

    // R6
    link_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(link_en) |-> (ptr_q[SEG_ALIGN_BITS-1:0] == '0));

endmodule

// File: rtl/trb_ring_fsm.sv
// Module: fetch controller of the ring walker.
// Issues one read per block, evaluates ownership, follows links, skips no-ops,
// forwards the rest, and honours pause (after current) and abort (at once).
// Assumes memory answers each accepted request exactly once, in order.
module trb_ring_fsm
    import trb_ring_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      doorbell,
    input  logic      load,
    input  logic      pause_req,
    input  logic      abort_req,
    input  logic      mem_req_ready,
    input  logic      mem_rsp_valid,
    input  logic      out_ready,
    input  trb_info_t info,
    output logic      mem_req_valid,
    output logic      capture,
    output logic      out_valid,
    output logic      adv,
    output logic      link_en,
    output logic      load_en,
    output logic      running
);

    fetch_st_t st_q, st_d;
    logic      pause_pend;
    logic      abort_pend;

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Purpose: latch stop requests while active; requests while idle are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q == ST_IDLE) begin
            pause_pend <= 1'b0;
            abort_pend <= 1'b0;
        end else begin
            pause_pend <= pause_pend | pause_req;
            abort_pend <= abort_pend | abort_req;
        end
    end

    // Purpose: next state and one-cycle datapath strobes.
    always_comb begin
        st_d    = st_q;
        adv     = 1'b0;
        link_en = 1'b0;
        capture = 1'b0;
        load_en = 1'b0;
        case (st_q)
            ST_IDLE: begin
                load_en = load;
                if (doorbell) st_d = ST_REQ;
            end
            ST_REQ: begin
                if (abort_pend || pause_pend) st_d = ST_IDLE;
                else if (mem_req_ready)       st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (abort_pend) begin
                        st_d = ST_IDLE;
                    end else begin
                        capture = 1'b1;
                        st_d    = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                if (abort_pend || !info.owned) begin
                    st_d = ST_IDLE;
                end else if (info.is_link) begin
                    link_en = 1'b1;
                    st_d    = pause_pend ? ST_IDLE : ST_REQ;
                end else if (info.is_noop) begin
                    adv  = 1'b1;
                    st_d = pause_pend ? ST_IDLE : ST_REQ;
                end else begin
                    st_d = ST_OUT;
                end
            end
            ST_OUT: begin
                if (abort_pend) begin
                    st_d = ST_IDLE;
                end else if (out_ready) begin
                    adv  = 1'b1;
                    st_d = pause_pend ? ST_IDLE : ST_REQ;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign mem_req_valid = (st_q == ST_REQ) && !abort_pend && !pause_pend;
    assign out_valid     = (st_q == ST_OUT) && !abort_pend;
    assign running       = (st_q != ST_IDLE);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !abort_req) |=> out_valid);

    // R3
    start_after_doorbell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(doorbell));

    // R3
    rsp_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (st_q == ST_WAIT));

    // R5
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EVAL && !info.owned) |=> !running);

    // R11
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OUT && abort_pend) |=> (!running && !out_valid));

endmodule

// File: rtl/trb_ring_consumer.sv
// Module: top of the cycle-flag transfer ring fetcher.
// Holds the fetched block, decodes it, and ties the controller to the
// pointer registers. Assumes ADDR_W <= 64 and a single-outstanding memory.
module trb_ring_consumer
    import trb_ring_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int SEG_ALIGN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              doorbell,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_ptr,
    input  logic              load_ccs,
    input  logic              pause_req,
    input  logic              abort_req,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [TRB_W-1:0]  mem_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_param,
    output logic [31:0]       out_status,
    output logic [TYPE_W-1:0] out_type,
    output logic              out_chain,
    output logic              out_ioc,
    output logic              running,
    output logic [ADDR_W-1:0] deq_ptr,
    output logic              ccs
);

    logic [TRB_W-1:0] trb_q;
    trb_info_t        info;
    logic             capture, adv, link_en, load_en;

    // Purpose: hold the block most recently returned by memory.
    always_ff @(posedge clk) begin
        if (!rst_n)       trb_q <= '0;
        else if (capture) trb_q <= mem_rsp_data;
    end

    trb_ring_decode u_dec (
        .ctrl (trb_q[CTRL_LSB +: 32]),
        .ccs  (ccs),
        .info (info)
    );

    trb_ring_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .doorbell      (doorbell),
        .load          (load),
        .pause_req     (pause_req),
        .abort_req     (abort_req),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .out_ready     (out_ready),
        .info          (info),
        .mem_req_valid (mem_req_valid),
        .capture       (capture),
        .out_valid     (out_valid),
        .adv           (adv),
        .link_en       (link_en),
        .load_en       (load_en),
        .running       (running)
    );

    trb_ring_ptr #(
        .ADDR_W         (ADDR_W),
        .TRB_BYTES      (TRB_BYTES),
        .SEG_ALIGN_BITS (SEG_ALIGN_BITS)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_ptr (load_ptr),
        .load_ccs (load_ccs),
        .adv      (adv),
        .link_en  (link_en),
        .link_ptr (trb_q[ADDR_W-1:0]),
        .link_tog (info.toggle),
        .ptr      (deq_ptr),
        .ccs      (ccs)
    );

    assign mem_req_addr = deq_ptr;
    assign out_param    = trb_q[63:0];
    assign out_status   = trb_q[95:64];
    assign out_type     = info.ttype;
    assign out_chain    = info.chain;
    assign out_ioc      = info.ioc;

    // R9
    out_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid && !out_ready) && out_valid) |->
            ($stable(out_param) && $stable(out_status) && $stable(out_type)));

endmodule

// File: tb/trb_ring_consumer_test.sv
module trb_ring_consumer_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    // expected forwarded stream: {param[31:0], type[5:0], chain, ioc}
    localparam logic [39:0] EXP_STREAM [6] = '{
        {32'hA0, 6'd1, 1'b1, 1'b0},
        {32'hA2, 6'd3, 1'b0, 1'b1},
        {32'hB0, 6'd1, 1'b1, 1'b1},
        {32'hB1, 6'd2, 1'b0, 1'b0},
        {32'hB2, 6'd4, 1'b0, 1'b1},
        {32'hC0, 6'd1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic doorbell = 1'b0, load = 1'b0, load_ccs = 1'b0;
    logic [AW-1:0] load_ptr = '0;
    logic pause_req = 1'b0, abort_req = 1'b0;
    logic mem_req_valid, mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic mem_rsp_valid;
    logic [127:0] mem_rsp_data;
    logic out_valid, out_ready = 1'b1;
    logic [63:0] out_param;
    logic [31:0] out_status;
    logic [5:0]  out_type;
    logic out_chain, out_ioc, running, ccs;
    logic [AW-1:0] deq_ptr;

    logic [127:0] mem [256];
    logic [39:0]  cap [8];
    int cap_n = 0;
    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trb_ring_consumer #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .load(load),
        .load_ptr(load_ptr), .load_ccs(load_ccs), .pause_req(pause_req),
        .abort_req(abort_req), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_param(out_param),
        .out_status(out_status), .out_type(out_type), .out_chain(out_chain),
        .out_ioc(out_ioc), .running(running), .deq_ptr(deq_ptr), .ccs(ccs)
    );

    // memory model: always ready, answers one cycle after the request
    assign mem_req_ready = 1'b1;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_rsp_valid <= mem_req_valid;
            mem_rsp_data  <= mem[mem_req_addr[11:4]];
        end
    end

    // stream monitor, sampled a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n && out_valid && out_ready) begin
            if (cap_n < 8) cap[cap_n] = {out_param[31:0], out_type, out_chain, out_ioc};
            cap_n++;
        end
    end

    function automatic logic [127:0] mk_trb(input logic [31:0] lo, input logic [5:0] typ,
                                            input logic cyc, input logic tog,
                                            input logic chn, input logic ioc);
        logic [31:0] ctrl;
        ctrl = {16'h0, typ, 4'h0, ioc, chn, 2'b00, tog, cyc};
        return {ctrl, lo + 32'h100, 32'h0, lo};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_load(input logic [AW-1:0] p, input logic c);
        @(negedge clk); load = 1'b1; load_ptr = p; load_ccs = c;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic ring;
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!running) break;
        end
    endtask

    task automatic wait_out;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (out_valid) break;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R3: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // segment at 0x000
        mem[8'h00] = mk_trb(32'hA0, 6'd1, 1'b1, 1'b0, 1'b1, 1'b0);
        mem[8'h01] = mk_trb(32'hA1, 6'd8, 1'b1, 1'b0, 1'b0, 1'b0);
        mem[8'h02] = mk_trb(32'hA2, 6'd3, 1'b1, 1'b0, 1'b0, 1'b1);
        mem[8'h03] = mk_trb(32'h425, 6'd6, 1'b1, 1'b1, 1'b0, 1'b0);
        // segment at 0x400, cycle flag 0 after toggle
        mem[8'h40] = mk_trb(32'hB0, 6'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        mem[8'h41] = mk_trb(32'hB1, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        mem[8'h42] = mk_trb(32'hB2, 6'd4, 1'b1, 1'b0, 1'b0, 1'b1);
        mem[8'h43] = mk_trb(32'hB3, 6'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        // segment at 0x800
        for (int i = 0; i < 4; i++)
            mem[8'h80 + i] = mk_trb(32'hC0 + i, 6'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        mem[8'h84] = mk_trb(32'hC4, 6'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        // segment at 0xC00: link without toggle
        mem[8'hC0] = mk_trb(32'h840, 6'd6, 1'b1, 1'b0, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 running", 64'(running), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 deq_ptr", 64'(deq_ptr), 64'd0);
        chk("R1 ccs", 64'(ccs), 64'd0);

        // R2: low 4 bits of the load address are dropped
        pulse_load(32'h0000_000B, 1'b1);
        chk("R2 load ptr", 64'(deq_ptr), 64'h0);
        chk("R2 load ccs", 64'(ccs), 64'd1);

        // first walk: skip no-op, follow toggling link, stop on unowned slot
        ring();
        chk("R3 running after doorbell", 64'(running), 64'd1);
        wait_idle();
        chk("R5 parked deq_ptr", 64'(deq_ptr), 64'h420);
        chk("R7 ccs inverted by link", 64'(ccs), 64'd0);
        chk("R5 forwarded count", 64'(cap_n), 64'd4);

        // hand the parked slot over and resume under backpressure
        mem[8'h42] = mk_trb(32'hB2, 6'd4, 1'b0, 1'b0, 1'b0, 1'b1);
        out_ready = 1'b0;
        ring();
        wait_out();
        chk("R5 resumed block", out_param, 64'hB2);
        chk("R4 status word", 64'(out_status), 64'h1B2);
        pulse_load(32'h800, 1'b1);
        repeat (2) @(negedge clk);
        chk("R9 valid held", 64'(out_valid), 64'd1);
        chk("R9 param held", out_param, 64'hB2);
        out_ready = 1'b1;
        wait_idle();
        chk("R2 load while running ignored ptr", 64'(deq_ptr), 64'h430);
        chk("R2 load while running ignored ccs", 64'(ccs), 64'd0);

        // R10 pause after the current block
        pulse_load(32'h800, 1'b1);
        out_ready = 1'b0;
        ring();
        wait_out();
        @(negedge clk); pause_req = 1'b1;
        @(negedge clk); pause_req = 1'b0; out_ready = 1'b1;
        wait_idle();
        chk("R10 deq_ptr after pause", 64'(deq_ptr), 64'h810);
        chk("R10 one block delivered", 64'(cap_n), 64'd6);

        // R11 abort drops the held block
        out_ready = 1'b0;
        ring();
        wait_out();
        @(negedge clk); abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 running", 64'(running), 64'd0);
        chk("R11 out_valid", 64'(out_valid), 64'd0);
        chk("R11 deq_ptr", 64'(deq_ptr), 64'h810);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 nothing delivered", 64'(cap_n), 64'd6);

        // R6/R7: link without toggle, aligned target, then unowned slot
        pulse_load(32'hC00, 1'b1);
        ring();
        wait_idle();
        chk("R6 link target", 64'(deq_ptr), 64'h840);
        chk("R7 ccs kept", 64'(ccs), 64'd1);

        // R4/R8: stream content in ring order, no-op A1 absent
        for (int i = 0; i < 6; i++)
            chk("R4 R8 stream entry", 64'(cap[i]), 64'(EXP_STREAM[i]));
        chk("R4 total forwarded", 64'(cap_n), 64'd6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule